// File: doc/BRIEF.md
# SCSI Asynchronous Data-Out Handshake Engine

The engine is the target-side sender of an asynchronous data-out phase. It drives the active-low REQ line and an 8-bit data bus, and it runs one REQ/ACK exchange for each byte. The bytes come from a valid/ready byte stream. A start pulse loads a transfer count. The engine then repeats the handshake until that count is used up, raises a one-cycle done pulse and returns to idle. While a transfer runs, the count can be raised, so a producer can hand over data in pieces without stopping the bus.

The initiator's ACK line is asynchronous. Inside the block it passes through a two-flop synchroniser, and edges are detected on the synchronised level only. A falling ACK releases REQ, and it also opens the stream for the next byte. That byte is fetched while ACK is low. A rising ACK re-asserts REQ at once if a byte is staged and the count is not used up.

The stream follows these back-pressure rules. The block raises `s_ready_o` only when all of these hold: REQ is deasserted, at least one byte is still owed, and no byte is already staged. A byte moves on any rising edge where both `s_valid_i` and `s_ready_o` are high. If the producer has no byte when a cycle would begin, REQ stays high until a byte arrives, so a stale value is never offered on the bus. A watchdog limits the total busy time. When it expires, the engine drops back to idle and sets an error flag. A synchronous abort does the same without setting the flag.

Top module: `scsi_dout_engine`

## Requirements
- R1: After reset the engine is idle: `req_n_o`=1, `req_drive_o`=0, `busy_o`=0, `done_o`=0, `err_o`=0, `s_ready_o`=0.
- R2: When `start_i` is high while the engine is idle, `count_i` is loaded and `busy_o` and `req_drive_o` rise on the next cycle. REQ stays high until the first byte is accepted. REQ goes low in the cycle after the byte is accepted, and `db_o` already holds that byte in that cycle.
- R3: `ack_n_i` is sampled by two flops. REQ changes on the third rising edge that samples a new ACK level. A falling ACK drives REQ high. A rising ACK drives REQ low again when a byte is staged and the remaining count is not zero.
- R4: `s_ready_o` is high only while busy with REQ high, a nonzero remaining count and no staged byte. A byte accepted while ACK is low appears on `db_o` in the next cycle. `db_o` does not change while REQ stays low.
- R5: If no byte has been accepted when ACK rises, REQ stays high until a byte is accepted. It then falls in the following cycle.
- R6: Each falling ACK seen while REQ is low uses one unit of count. On the rising ACK that follows the last unit, `done_o` pulses for one cycle and `busy_o` falls on the same edge.
- R7: While busy, an `extend_i` pulse adds `count_i` to the remaining count. `extend_i` has no effect while idle, and `start_i` has no effect while busy.
- R8: If the engine stays busy for `WD_CYCLES` cycles, it returns to idle without a done pulse and sets `err_o`. `err_o` stays set until the next accepted start.
- R9: An `abort_i` pulse returns the engine to idle on the next edge from any state, with REQ high, `req_drive_o` low, no done pulse and no change to `err_o`.
- R10: A start with a count of zero gives a done pulse two cycles after the start edge. It never asserts REQ and never accepts a byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a transfer (idle only) |
| count_i | input | CNT_W | Byte count for start or extend |
| extend_i | input | 1 | Add `count_i` to the remaining count while busy |
| abort_i | input | 1 | Return to idle at once |
| s_valid_i | input | 1 | Stream byte valid |
| s_data_i | input | DATA_W | Stream byte |
| s_ready_o | output | 1 | Engine takes the stream byte |
| ack_n_i | input | 1 | Initiator ACK, active low, asynchronous |
| req_n_o | output | 1 | REQ, active low |
| req_drive_o | output | 1 | Engine owns REQ and the data bus |
| db_o | output | DATA_W | Data bus value |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Watchdog expiry flag |

## Verification
The hardest case to reach is an ACK rise that arrives when no byte is staged. The producer must miss the whole window during which ACK is low. The bench reaches it by offering exactly one byte against a count of two, completing one handshake and then holding the stream empty for many cycles before supplying the second byte. A second hard case is a count extension landing mid-transfer. The bench reaches it by forking the extend pulse alongside the initiator that is serving handshakes, so that the extension arrives while bytes are in flight.

// File: rtl/sde_pkg.sv
package sde_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_REQ  = 2'd2,
    ST_HOLD = 2'd3
  } sde_state_t;
endpackage

// File: rtl/sde_ack_sync.sv
module sde_ack_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ack_n_i,
  output logic fall_o,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;
  logic              lvl;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= ack_n_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[STAGES-2:0], ack_n_i};
      end
    end
  endgenerate

  assign lvl = sync_q[STAGES-1];

  always_ff @(posedge clk) begin
    if (!rst_n) last_q <= 1'b1;
    else        last_q <= lvl;
  end

  assign fall_o = last_q & ~lvl;
  assign rise_o = ~last_q & lvl;
endmodule

// File: rtl/sde_count.sv
module sde_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             add_i,
  input  logic [CNT_W-1:0] add_val_i,
  input  logic             dec_i,
  output logic [CNT_W-1:0] rem_o,
  output logic             zero_o
);
  logic [CNT_W-1:0] rem_q;
  logic [CNT_W-1:0] plus;
  logic [CNT_W-1:0] rem_d;

  always_comb begin
    plus  = add_i ? add_val_i : '0;
    rem_d = rem_q + plus - {{(CNT_W-1){1'b0}}, dec_i};
    if (load_i) rem_d = load_val_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rem_q <= '0;
    else        rem_q <= rem_d;
  end

  assign rem_o  = rem_q;
  assign zero_o = (rem_q == '0);
endmodule

// File: rtl/sde_watchdog.sv
module sde_watchdog #(
  parameter int LIMIT = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic expire_o
);
  localparam int W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt_q <= '0;
    else if (run_i) cnt_q <= cnt_q + 1'b1;
    else            cnt_q <= '0;
  end

  assign expire_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/scsi_dout_engine.sv
module scsi_dout_engine
  import sde_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int WD_CYCLES   = 625_000_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              extend_i,
  input  logic              abort_i,
  input  logic              s_valid_i,
  input  logic [DATA_W-1:0] s_data_i,
  output logic              s_ready_o,
  input  logic              ack_n_i,
  output logic              req_n_o,
  output logic              req_drive_o,
  output logic [DATA_W-1:0] db_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o
);
  sde_state_t        state_q, state_d;
  logic              staged_q, staged_d;
  logic [DATA_W-1:0] db_q, db_d;
  logic              done_q, done_d;
  logic              err_q, err_d;

  logic              ack_fall, ack_rise;
  logic [CNT_W-1:0]  rem;
  logic              rem_zero;
  logic              wd_expire;
  logic              busy;
  logic              accept;
  logic              kill;
  logic              cnt_load, cnt_add, cnt_dec;

  sde_ack_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .ack_n_i (ack_n_i),
    .fall_o  (ack_fall),
    .rise_o  (ack_rise)
  );

  sde_count #(.CNT_W(CNT_W)) u_count (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (cnt_load),
    .load_val_i (count_i),
    .add_i      (cnt_add),
    .add_val_i  (count_i),
    .dec_i      (cnt_dec),
    .rem_o      (rem),
    .zero_o     (rem_zero)
  );

  sde_watchdog #(.LIMIT(WD_CYCLES)) u_wd (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_i    (busy),
    .expire_o (wd_expire)
  );

  assign busy      = (state_q != ST_IDLE);
  assign s_ready_o = ((state_q == ST_LOAD) || (state_q == ST_HOLD)) && !rem_zero && !staged_q;
  assign accept    = s_valid_i && s_ready_o;
  assign kill      = abort_i || wd_expire;

  assign cnt_load  = (state_q == ST_IDLE) && start_i;
  assign cnt_add   = busy && extend_i;
  assign cnt_dec   = (state_q == ST_REQ) && ack_fall;

  always_comb begin
    state_d  = state_q;
    staged_d = staged_q;
    db_d     = db_q;
    done_d   = 1'b0;
    err_d    = err_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d  = ST_LOAD;
          staged_d = 1'b0;
          err_d    = 1'b0;
        end
      end
      ST_LOAD: begin
        if (rem_zero) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end else if (accept) begin
          db_d    = s_data_i;
          state_d = ST_REQ;
        end
      end
      ST_REQ: begin
        if (ack_fall) state_d = ST_HOLD;
      end
      ST_HOLD: begin
        if (accept) begin
          db_d     = s_data_i;
          staged_d = 1'b1;
        end
        if (ack_rise) begin
          if (rem_zero) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
          end else if (staged_q || accept) begin
            state_d  = ST_REQ;
            staged_d = 1'b0;
          end else begin
            state_d = ST_LOAD;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
    if (kill) begin
      state_d  = ST_IDLE;
      staged_d = 1'b0;
      done_d   = 1'b0;
      err_d    = err_q | (wd_expire & ~abort_i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      staged_q <= 1'b0;
      db_q     <= '0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      state_q  <= state_d;
      staged_q <= staged_d;
      db_q     <= db_d;
      done_q   <= done_d;
      err_q    <= err_d;
    end
  end

  assign req_n_o     = (state_q != ST_REQ);
  assign req_drive_o = busy;
  assign db_o        = db_q;
  assign busy_o      = busy;
  assign done_o      = done_q;
  assign err_o       = err_q;
endmodule

// File: rtl/sde_checker.sv
module sde_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              abort_i,
  input logic              s_ready_o,
  input logic              req_n_o,
  input logic              req_drive_o,
  input logic [DATA_W-1:0] db_o,
  input logic              busy_o,
  input logic              done_o,
  input logic              err_o
);
  p_req_owned_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_n_o |-> req_drive_o);

  p_ready_req_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready_o |-> (req_n_o && busy_o));

  p_bus_steady_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_n_o && $past(!req_n_o)) |-> $stable(db_o));

  p_done_closes_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(busy_o)));

  p_err_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_o) |-> (!done_o && !busy_o && req_n_o));

  p_abort_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    abort_i |=> (!busy_o && req_n_o && !req_drive_o && !done_o));
endmodule

bind scsi_dout_engine sde_checker #(.DATA_W(DATA_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .abort_i     (abort_i),
  .s_ready_o   (s_ready_o),
  .req_n_o     (req_n_o),
  .req_drive_o (req_drive_o),
  .db_o        (db_o),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .err_o       (err_o)
);

// File: tb/scsi_dout_engine_tb_top.sv
`timescale 1ns/1ps
module scsi_dout_engine_tb_top;
  localparam int CW = 8;
  localparam int DW = 8;
  localparam int WD = 400;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 0, extend_i = 0, abort_i = 0, s_valid_i = 0, ack_n_i = 1;
  logic [CW-1:0] count_i = '0;
  logic [DW-1:0] s_data_i = '0;
  logic s_ready_o, req_n_o, req_drive_o, busy_o, done_o, err_o;
  logic [DW-1:0] db_o;

  always #4 clk = ~clk;

  scsi_dout_engine #(.CNT_W(CW), .DATA_W(DW), .SYNC_STAGES(2), .WD_CYCLES(WD)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .count_i(count_i),
    .extend_i(extend_i), .abort_i(abort_i), .s_valid_i(s_valid_i),
    .s_data_i(s_data_i), .s_ready_o(s_ready_o), .ack_n_i(ack_n_i),
    .req_n_o(req_n_o), .req_drive_o(req_drive_o), .db_o(db_o),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o));

  int checks = 0;
  int errors = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  int m_st = 0, m_rem = 0, m_db = 0, m_wd = 0;
  bit m_stg = 0, m_done = 0, m_err = 0, m_acc = 0;
  bit h1 = 1, h2 = 1, h3 = 1;
  int n_st, n_rem, n_db;
  bit n_stg, n_done, n_err, f_fall, f_rise, f_busy, f_zero, f_rdy, f_acc, f_wdx, f_kill;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_rem = 0; m_db = 0; m_wd = 0; m_stg = 0;
      m_done = 0; m_err = 0; m_acc = 0; h1 = 1; h2 = 1; h3 = 1;
    end else begin
      f_fall = h3 && !h2;
      f_rise = !h3 && h2;
      f_busy = (m_st != 0);
      f_zero = (m_rem == 0);
      f_rdy  = (m_st == 1 || m_st == 3) && !f_zero && !m_stg;
      f_acc  = f_rdy && s_valid_i;
      f_wdx  = f_busy && (m_wd == WD - 1);
      f_kill = abort_i || f_wdx;
      n_st = m_st; n_stg = m_stg; n_db = m_db; n_done = 0; n_err = m_err;
      n_rem = m_rem;
      if (m_st == 0 && start_i) n_rem = int'(count_i);
      else begin
        if (f_busy && extend_i) n_rem = n_rem + int'(count_i);
        if (m_st == 2 && f_fall) n_rem = n_rem - 1;
      end
      n_rem = n_rem & ((1 << CW) - 1);
      case (m_st)
        0: if (start_i) begin n_st = 1; n_stg = 0; n_err = 0; end
        1: if (f_zero) begin n_st = 0; n_done = 1; end
           else if (f_acc) begin n_db = int'(s_data_i); n_st = 2; end
        2: if (f_fall) n_st = 3;
        default: begin
          if (f_acc) begin n_db = int'(s_data_i); n_stg = 1; end
          if (f_rise) begin
            if (f_zero) begin n_st = 0; n_done = 1; end
            else if (m_stg || f_acc) begin n_st = 2; n_stg = 0; end
            else n_st = 1;
          end
        end
      endcase
      if (f_kill) begin
        n_st = 0; n_stg = 0; n_done = 0;
        if (f_wdx && !abort_i) n_err = 1;
      end
      m_wd = f_busy ? m_wd + 1 : 0;
      h3 = h2; h2 = h1; h1 = ack_n_i;
      m_st = n_st; m_rem = n_rem; m_db = n_db; m_stg = n_stg;
      m_done = n_done; m_err = n_err; m_acc = f_acc;
    end
  end

  // Compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R3 req_n", int'(req_n_o), int'(m_st != 2));
      chk("R2 req_drive", int'(req_drive_o), int'(m_st != 0));
      chk("R4 db", int'(db_o), m_db);
      chk("R6 busy", int'(busy_o), int'(m_st != 0));
      chk("R6 done", int'(done_o), int'(m_done));
      chk("R8 err", int'(err_o), int'(m_err));
      chk("R4 s_ready", int'(s_ready_o),
          int'((m_st == 1 || m_st == 3) && m_rem != 0 && !m_stg));
    end
  end

  // Byte source
  logic [DW-1:0] src_q[$];
  logic [DW-1:0] got_q[$];
  logic [DW-1:0] exp_q[$];
  bit src_hold = 0;

  always @(negedge clk) begin
    #1;
    if (m_acc && src_q.size() > 0) void'(src_q.pop_front());
    m_acc = 0;
    s_valid_i = (src_q.size() > 0) && !src_hold;
    s_data_i  = (src_q.size() > 0) ? src_q[0] : '0;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
    #2;
  endtask

  task automatic pulse_start(input int n);
    @(negedge clk); #2; start_i = 1; count_i = CW'(n);
    @(negedge clk); #2; start_i = 0;
  endtask

  task automatic pulse_extend(input int n);
    @(negedge clk); #2; extend_i = 1; count_i = CW'(n);
    @(negedge clk); #2; extend_i = 0;
  endtask

  task automatic push(input int first, input int n);
    for (int i = 0; i < n; i++) begin
      src_q.push_back(DW'(first + i));
      exp_q.push_back(DW'(first + i));
    end
  endtask

  task automatic serve(input int n, input int d1, input int d2);
    for (int i = 0; i < n; i++) begin
      while (req_n_o !== 1'b0) @(negedge clk);
      repeat (d1) @(negedge clk);
      #2; ack_n_i = 0; got_q.push_back(db_o);
      while (req_n_o !== 1'b1) @(negedge clk);
      repeat (d2) @(negedge clk);
      #2; ack_n_i = 1;
    end
  endtask

  task automatic compare_bytes(input string tag);
    chk({tag, " byte count"}, got_q.size(), exp_q.size());
    for (int i = 0; i < got_q.size() && i < exp_q.size(); i++)
      chk({tag, " byte"}, int'(got_q[i]), int'(exp_q[i]));
    got_q.delete(); exp_q.delete();
  endtask

  task automatic wait_idle();
    int g = 0;
    while (busy_o && g < 2000) begin @(negedge clk); g++; end
    #2;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run hung, actual=running expected=finished");
    finish_run();
  end

  bit saw_done;

  initial begin
    tick(4);
    // R1 reset state
    chk("R1 req_n", int'(req_n_o), 1);
    chk("R1 drive", int'(req_drive_o), 0);
    chk("R1 busy", int'(busy_o), 0);
    chk("R1 done", int'(done_o), 0);
    chk("R1 err", int'(err_o), 0);
    chk("R1 ready", int'(s_ready_o), 0);
    rst_n = 1;
    tick(2);

    // R2 / R6: plain transfer, plus a start while busy (ignored, R7)
    pulse_start(5);
    tick(3);
    chk("R2 req high before data", int'(req_n_o), 1);
    chk("R2 busy", int'(busy_o), 1);
    push(8'h10, 5);
    fork
      serve(5, 1, 1);
      begin tick(12); start_i = 1; count_i = 8'd50; tick(1); start_i = 0; end
    join
    wait_idle();
    tick(3);
    compare_bytes("R6 five-byte");
    chk("R7 start ignored while busy", int'(busy_o), 0);

    // R3: exact synchroniser latency, manual ACK
    push(8'hA5, 1);
    pulse_start(1);
    while (req_n_o !== 1'b0) @(negedge clk);
    #2; ack_n_i = 0;
    tick(1); chk("R3 req after 1 edge", int'(req_n_o), 0);
    tick(1); chk("R3 req after 2 edges", int'(req_n_o), 0);
    tick(1); chk("R3 req after 3 edges", int'(req_n_o), 1);
    chk("R3 data on bus", int'(db_o), 8'hA5);
    ack_n_i = 1;
    tick(2); chk("R6 done not yet", int'(done_o), 0);
    tick(1); chk("R6 done pulse", int'(done_o), 1);
    chk("R6 busy low with done", int'(busy_o), 0);
    tick(1); chk("R6 done one cycle", int'(done_o), 0);
    exp_q.delete();

    // R5: stream starved at ACK rise
    push(8'h31, 1);
    pulse_start(2);
    serve(1, 2, 2);
    tick(15);
    chk("R5 req held high while starved", int'(req_n_o), 1);
    chk("R5 still busy", int'(busy_o), 1);
    push(8'h32, 1);
    serve(1, 1, 3);
    wait_idle();
    compare_bytes("R5 starved");

    // R7: extend while running, extend while idle ignored
    push(8'h50, 6);
    pulse_start(3);
    fork
      serve(6, 2, 2);
      begin tick(6); pulse_extend(3); end
    join
    wait_idle();
    compare_bytes("R7 extended");
    pulse_extend(9);
    tick(3);
    chk("R7 extend idle busy", int'(busy_o), 0);
    push(8'h70, 2);
    pulse_start(2);
    serve(2, 1, 1);
    wait_idle();
    tick(4);
    chk("R7 idle extend no extra req", int'(req_n_o), 1);
    compare_bytes("R7 idle extend");

    // R10: zero count
    pulse_start(0);
    tick(1);
    chk("R10 done after zero start", int'(done_o), 1);
    chk("R10 no req", int'(req_n_o), 1);

    // R9: abort mid transfer
    push(8'h90, 4);
    pulse_start(4);
    serve(1, 1, 1);
    tick(2);
    @(negedge clk); #2; abort_i = 1;
    @(negedge clk); #2; abort_i = 0;
    chk("R9 abort busy", int'(busy_o), 0);
    chk("R9 abort req", int'(req_n_o), 1);
    chk("R9 abort err unchanged", int'(err_o), 0);
    tick(3);
    src_q.delete(); got_q.delete(); exp_q.delete();
    tick(2);

    // R8: watchdog with a silent initiator
    push(8'hC0, 2);
    pulse_start(2);
    saw_done = 0;
    for (int i = 0; i < WD + 10; i++) begin
      @(negedge clk);
      if (done_o) saw_done = 1;
    end
    #2;
    chk("R8 err set", int'(err_o), 1);
    chk("R8 idle", int'(busy_o), 0);
    chk("R8 drive released", int'(req_drive_o), 0);
    chk("R8 no done", int'(saw_done), 0);
    src_q.delete(); exp_q.delete();
    tick(2);
    pulse_start(0);
    chk("R8 err cleared by start", int'(err_o), 0);
    tick(4);

    finish_run();
  end
endmodule